// File: doc/BRIEF.md
# Selectable Registered Command Buffer

This block sits on the command and address bus between a memory controller and a bank of SDRAM devices. It takes the row and column address, the bank select, the three command strobes (RAS, CAS, WE, all active low), the chip selects and the clock enables. A static mode input picks how they reach the devices. In transparent mode the outputs follow the inputs combinationally. In registered mode every signal is captured on the rising clock edge and held until the next edge, so each command reaches the devices exactly one cycle after the controller issued it.

The controller must allow for that extra cycle. A read issued at the pins returns data one clock later than the device CAS latency alone would suggest. Write data is not buffered, so the controller presents the first write beat one clock after the write command. The address, bank and strobe outputs are duplicated into `COPIES` identical groups, one group for each half of the device array. Chip selects and clock enables are emitted once and go through the same path as the rest of the command. A synchronous reset loads the capture register with a no-operation word.

Top module: `cmd_regbuf`

## Requirements
- R1: When `reg_mode_i` is 0, every output field equals the corresponding input field in the same cycle, with no clock delay. This holds whether or not reset is asserted.
- R2: When `reg_mode_i` is 1, every output field equals the value its input had at the previous rising clock edge, and it stays stable between edges. A command therefore appears at the outputs one cycle after it appears at the inputs, with order preserved and none dropped or repeated.
- R3: Only a driven 0 on `reg_mode_i` selects transparent mode. A 1, or an unknown or undriven level, selects registered mode. In registered mode a change on the inputs does not reach the outputs before the next rising edge.
- R4: A rising edge with `rst` high loads the capture register with the no-operation word: address 0, bank 0, RAS/CAS/WE all 1, every chip select 1 (deselected) and every clock enable 1. In registered mode that word is what appears at the outputs in the cycle after the reset edge.
- R5: The address, bank, RAS, CAS and WE outputs are presented as `COPIES` groups. Copy k occupies `addr_o[k*13 +: 13]`, `ba_o[k*2 +: 2]`, `ras_n_o[k]`, `cas_n_o[k]` and `we_n_o[k]`, and all copies are identical at all times.
- R6: The chip-select and clock-enable outputs are single copies, and they take exactly the same path and delay as the address and strobes in the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the capture register |
| reg_mode_i | input | 1 | 1 or undriven selects registered mode; 0 selects transparent mode |
| addr_i | input | 13 | Multiplexed row/column address from the controller |
| ba_i | input | 2 | Bank select from the controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| cs_n_i | input | 4 | Chip selects, active low |
| cke_i | input | 1 | Clock enable |
| addr_o | output | 13*COPIES | Buffered address, one group per copy |
| ba_o | output | 2*COPIES | Buffered bank select, one group per copy |
| ras_n_o | output | COPIES | Buffered row strobe, one bit per copy |
| cas_n_o | output | COPIES | Buffered column strobe, one bit per copy |
| we_n_o | output | COPIES | Buffered write enable, one bit per copy |
| cs_n_o | output | 4 | Buffered chip selects |
| cke_o | output | 1 | Buffered clock enable |

## Verification
The properties assume that the mode input is static while the block runs. Each latency check applies only when the mode was also high at the previous edge and reset was low there, so a change of mode is never judged against a stale capture. The stimulus changes mode only between phases. It starts each registered phase either from a reset or from a register that has been capturing all along, and it drives every input at the falling edge, so no setup relation to the capture edge is ever ambiguous.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int CS_W   = 4;
    localparam int CKE_W  = 1;

    // One command word as it travels through the buffer.
    typedef struct packed {
        logic [CKE_W-1:0]  cke;
        logic [CS_W-1:0]   cs_n;
        logic              we_n;
        logic              cas_n;
        logic              ras_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } cmd_word_t;

    localparam int CMD_W = $bits(cmd_word_t);

    typedef enum logic {
        PATH_FLOW = 1'b0,
        PATH_PIPE = 1'b1
    } path_sel_e;

    // Word loaded by reset: every device deselected, strobes idle.
    function automatic cmd_word_t idle_word();
        cmd_word_t w;
        w.cke   = '1;
        w.cs_n  = '1;
        w.we_n  = 1'b1;
        w.cas_n = 1'b1;
        w.ras_n = 1'b1;
        w.ba    = '0;
        w.addr  = '0;
        return w;
    endfunction

    // Only a clean 0 picks the flow-through path; anything else pipelines.
    function automatic path_sel_e decode_mode(input logic mode);
        path_sel_e s;
        if (mode == 1'b0) s = PATH_FLOW;
        else              s = PATH_PIPE;
        return s;
    endfunction

endpackage

// File: rtl/cmd_capture_stage.sv
module cmd_capture_stage
    import cmd_regbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_word_t word_i,
    output cmd_word_t word_q
);

    always_ff @(posedge clk) begin
        if (rst) word_q <= idle_word();
        else     word_q <= word_i;
    end

endmodule

// File: rtl/cmd_path_select.sv
module cmd_path_select
    import cmd_regbuf_pkg::*;
(
    input  logic      mode_i,
    input  cmd_word_t live_i,
    input  cmd_word_t held_i,
    output cmd_word_t word_o
);

    path_sel_e sel;

    always_comb begin
        sel = decode_mode(mode_i);
        if (sel == PATH_FLOW) word_o = live_i;
        else                  word_o = held_i;
    end

endmodule

// File: rtl/cmd_copy_fanout.sv
module cmd_copy_fanout
    import cmd_regbuf_pkg::*;
#(
    parameter int COPIES = 2
) (
    input  cmd_word_t                  word_i,
    output logic [COPIES*ADDR_W-1:0]   addr_o,
    output logic [COPIES*BA_W-1:0]     ba_o,
    output logic [COPIES-1:0]          ras_n_o,
    output logic [COPIES-1:0]          cas_n_o,
    output logic [COPIES-1:0]          we_n_o,
    output logic [CS_W-1:0]            cs_n_o,
    output logic [CKE_W-1:0]           cke_o
);

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        assign addr_o[k*ADDR_W +: ADDR_W] = word_i.addr;
        assign ba_o[k*BA_W +: BA_W]       = word_i.ba;
        assign ras_n_o[k]                 = word_i.ras_n;
        assign cas_n_o[k]                 = word_i.cas_n;
        assign we_n_o[k]                  = word_i.we_n;
    end

    assign cs_n_o = word_i.cs_n;
    assign cke_o  = word_i.cke;

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
    import cmd_regbuf_pkg::*;
#(
    parameter int COPIES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_mode_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BA_W-1:0]             ba_i,
    input  logic                        ras_n_i,
    input  logic                        cas_n_i,
    input  logic                        we_n_i,
    input  logic [CS_W-1:0]             cs_n_i,
    input  logic [CKE_W-1:0]            cke_i,
    output logic [COPIES*ADDR_W-1:0]    addr_o,
    output logic [COPIES*BA_W-1:0]      ba_o,
    output logic [COPIES-1:0]           ras_n_o,
    output logic [COPIES-1:0]           cas_n_o,
    output logic [COPIES-1:0]           we_n_o,
    output logic [CS_W-1:0]             cs_n_o,
    output logic [CKE_W-1:0]            cke_o
);

    cmd_word_t live_w;
    cmd_word_t held_w;
    cmd_word_t sel_w;

    always_comb begin
        live_w.cke   = cke_i;
        live_w.cs_n  = cs_n_i;
        live_w.we_n  = we_n_i;
        live_w.cas_n = cas_n_i;
        live_w.ras_n = ras_n_i;
        live_w.ba    = ba_i;
        live_w.addr  = addr_i;
    end

    cmd_capture_stage u_capture (
        .clk    (clk),
        .rst    (rst),
        .word_i (live_w),
        .word_q (held_w)
    );

    cmd_path_select u_select (
        .mode_i (reg_mode_i),
        .live_i (live_w),
        .held_i (held_w),
        .word_o (sel_w)
    );

    cmd_copy_fanout #(.COPIES(COPIES)) u_fanout (
        .word_i  (sel_w),
        .addr_o  (addr_o),
        .ba_o    (ba_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o),
        .cs_n_o  (cs_n_o),
        .cke_o   (cke_o)
    );

endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk
    import cmd_regbuf_pkg::*;
#(
    parameter int COPIES = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_mode_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [BA_W-1:0]             ba_i,
    input logic                        ras_n_i,
    input logic                        cas_n_i,
    input logic                        we_n_i,
    input logic [CS_W-1:0]             cs_n_i,
    input logic [CKE_W-1:0]            cke_i,
    input logic [COPIES*ADDR_W-1:0]    addr_o,
    input logic [COPIES*BA_W-1:0]      ba_o,
    input logic [COPIES-1:0]           ras_n_o,
    input logic [COPIES-1:0]           cas_n_o,
    input logic [COPIES-1:0]           we_n_o,
    input logic [CS_W-1:0]             cs_n_o,
    input logic [CKE_W-1:0]            cke_o
);

    logic [ADDR_W+BA_W+2:0] in_grp;
    logic [ADDR_W+BA_W+2:0] out_grp0;
    logic [CS_W+CKE_W-1:0]  in_sel;
    logic [CS_W+CKE_W-1:0]  out_sel;

    assign in_grp   = {we_n_i, cas_n_i, ras_n_i, ba_i, addr_i};
    assign out_grp0 = {we_n_o[0], cas_n_o[0], ras_n_o[0], ba_o[BA_W-1:0], addr_o[ADDR_W-1:0]};
    assign in_sel   = {cke_i, cs_n_i};
    assign out_sel  = {cke_o, cs_n_o};

    // R1
    flow_path_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_mode_i == 1'b0) |-> (out_grp0 == in_grp && out_sel == in_sel));

    // R2
    pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_mode_i == 1'b1 && $past(reg_mode_i) == 1'b1 && !$past(rst))
            |-> (out_grp0 == $past(in_grp)));

    // R4
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && reg_mode_i == 1'b1)
            |-> (addr_o[ADDR_W-1:0] == '0 && ba_o[BA_W-1:0] == '0 && ras_n_o[0] && cas_n_o[0]
                 && we_n_o[0] && (&cs_n_o) && (&cke_o)));

    // R6
    sel_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_mode_i == 1'b1 && $past(reg_mode_i) == 1'b1 && !$past(rst))
            |-> (out_sel == $past(in_sel)));

    // R5
    for (genvar k = 1; k < COPIES; k++) begin : g_cp
        copy_match_chk: assert property (@(posedge clk) disable iff (rst)
            ({we_n_o[k], cas_n_o[k], ras_n_o[k], ba_o[k*BA_W +: BA_W], addr_o[k*ADDR_W +: ADDR_W]}
                == out_grp0));
    end

endmodule

bind cmd_regbuf cmd_regbuf_chk #(.COPIES(COPIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_mode_i (reg_mode_i),
    .addr_i     (addr_i),
    .ba_i       (ba_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .cs_n_i     (cs_n_i),
    .cke_i      (cke_i),
    .addr_o     (addr_o),
    .ba_o       (ba_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .cs_n_o     (cs_n_o),
    .cke_o      (cke_o)
);

// File: tb/cmd_regbuf_bench.sv
module cmd_regbuf_bench;

    localparam int CP = 2;
    localparam logic [22:0] IDLE = {1'b1, 4'hF, 3'b111, 2'b00, 13'h0000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_mode = 1'b1;
    logic [12:0] addr_i = '0;
    logic [1:0]  ba_i = '0;
    logic ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [3:0]  cs_n_i = 4'hF;
    logic [0:0]  cke_i = 1'b1;
    logic [CP*13-1:0] addr_o;
    logic [CP*2-1:0]  ba_o;
    logic [CP-1:0]    ras_n_o, cas_n_o, we_n_o;
    logic [3:0]       cs_n_o;
    logic [0:0]       cke_o;

    int checks = 0;
    int fails  = 0;
    logic [22:0] exp_reg = IDLE;
    logic primed = 1'b0;
    logic last_rst = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cmd_regbuf #(.COPIES(CP)) u_cmd_regbuf (
        .clk(clk), .rst(rst), .reg_mode_i(reg_mode),
        .addr_i(addr_i), .ba_i(ba_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
        .we_n_i(we_n_i), .cs_n_i(cs_n_i), .cke_i(cke_i),
        .addr_o(addr_o), .ba_o(ba_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
        .we_n_o(we_n_o), .cs_n_o(cs_n_o), .cke_o(cke_o)
    );

    function automatic logic [22:0] observe(input int k);
        return {cke_o, cs_n_o, we_n_o[k], cas_n_o[k], ras_n_o[k],
                ba_o[k*2 +: 2], addr_o[k*13 +: 13]};
    endfunction

    task automatic check_all(input string req, input logic [22:0] exp);
        for (int k = 0; k < CP; k++) begin
            checks++;
            if (observe(k) !== exp) begin
                fails++;
                $display("FAIL %s copy %0d: actual %h expected %h", req, k, observe(k), exp);
            end
        end
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic step(input logic [22:0] s, input logic r);
        @(negedge clk);
        if (reg_mode && primed) begin
            // R2 R5 R6 (R4 right after reset)
            check_all(last_rst ? "R4" : "R2/R6", exp_reg);
        end
        {cke_i, cs_n_i, we_n_i, cas_n_i, ras_n_i, ba_i, addr_i} = s;
        rst = r;
        #1;
        if (!reg_mode) check_all("R1", s);
        else if (primed && s != exp_reg) check_all("R3", exp_reg);
        exp_reg  = r ? IDLE : s;
        last_rst = r;
        primed   = 1'b1;
    endtask

    function automatic logic [22:0] mk(input logic [7:0] ctl, input logic [31:0] rnd);
        return {ctl[7], ctl[6:3], ctl[2], ctl[1], ctl[0], rnd[14:13], rnd[12:0]};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // registered mode, reset held (R4)
        for (int i = 0; i < 3; i++) begin
            lfsr = next_lfsr(lfsr);
            step(lfsr[22:0], 1'b1);
        end
        // registered control sweep (R2, R3, R5, R6)
        for (int i = 0; i < 256; i++) begin
            lfsr = next_lfsr(lfsr);
            step(mk(i[7:0], lfsr), 1'b0);
        end
        // transparent control sweep (R1, R5, R6)
        @(negedge clk);
        reg_mode = 1'b0;
        for (int i = 0; i < 256; i++) begin
            lfsr = next_lfsr(lfsr);
            step(mk(8'(255 - i), lfsr), 1'b0);
        end
        // reset while transparent: outputs still follow (R1)
        for (int i = 0; i < 2; i++) begin
            lfsr = next_lfsr(lfsr);
            step(lfsr[22:0], 1'b1);
        end
        // back to registered: first word is the idle word (R4)
        reg_mode = 1'b1;
        for (int i = 0; i < 120; i++) begin
            lfsr = next_lfsr(lfsr);
            step(lfsr[22:0], 1'b0);
        end
        // flush last captured word (R2)
        step(exp_reg, 1'b0);
        @(negedge clk);
        check_all("R2", exp_reg);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule